// File: doc/BRIEF.md
# Home Directory Controller with Sharer Vector

The block is the home-node coherence engine for a small set of memory blocks. For every block it keeps a coherence state (Uncached, Shared or Exclusive) and a sharer bit vector with one bit per processor. Caches send it read misses, write misses and data write-backs. It updates the directory entry, reads or writes the backing memory it owns, and sends data replies, invalidations, fetches and fetch-with-invalidate messages back to the caches.

One request is handled at a time. A write miss to a shared block walks the sharer vector and sends one invalidation per cycle, lowest processor number first, and sends the data reply only after the last one. A miss to an exclusive block recalls the data from its owner and holds off new requests until the owner answers on the response port. A parameter can cap how many sharers are tracked. When a new reader would go past that cap, a per-block broadcast flag is set, and the next write miss to that block invalidates every processor except the writer.

Top module: `dir_home_ctrl`

## Requirements
- R1: During and after synchronous reset, `req_ready` is 1 and `msg_valid` is 0. Every block is Uncached, and block b holds the word 0xB000 + b.
- R2: A read miss (`req_kind` 0) to an Uncached or Shared block causes exactly one data reply (`msg_kind` 0) to the requester, in the cycle after acceptance. The reply carries the block's memory word. The requester is added to the sharers and the block becomes Shared.
- R3: A write miss (`req_kind` 1) to an Uncached block causes exactly one data reply with the memory word. The block becomes Exclusive with the requester as its only sharer.
- R4: A write miss to a Shared block sends one invalidation (`msg_kind` 1) per cycle to each sharer other than the requester, in ascending processor order. The data reply follows in the cycle after the last invalidation. The requester becomes the sole owner.
- R5: A read miss to an Exclusive block sends a fetch (`msg_kind` 2) to the owner. When `rsp_valid` arrives, the returned word is written to memory and replied to the requester. The block becomes Shared with both the old owner and the requester as sharers.
- R6: A write miss to an Exclusive block sends a fetch-invalidate (`msg_kind` 3) to the owner and forwards the returned word to the requester. The requester becomes the new sole owner.
- R7: A write-back (`req_kind` 2) from the owner of an Exclusive block writes `req_data` to memory, clears the sharers and makes the block Uncached, with no message.
- R8: A write-back to a block that is not Exclusive, or that comes from a processor other than the owner, changes neither memory nor the directory and sends no message.
- R9: Request code 3 is accepted and has no effect.
- R10: `req_ready` is 0 while invalidations are pending or a recall is outstanding. It is 1 in every cycle that shows a data reply. No message other than the fetch appears while waiting for the owner.
- R11: With a sharer limit set and not exceeded, a write miss invalidates only the tracked sharers.
- R12: When a new reader would exceed the sharer limit, it is not tracked and the block's broadcast flag is set. The next write miss then invalidates every processor except the requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken on this edge |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 no operation |
| req_proc | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | input | 1 | Owner's data returned after fetch |
| rsp_data | input | DATA_W | Returned owner data |
| msg_valid | output | 1 | Outgoing message valid (one cycle) |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-invalidate |
| msg_dest | output | $clog2(NPROC) | Destination processor |
| msg_blk | output | $clog2(NBLK) | Block index of the message |
| msg_data | output | DATA_W | Reply data (0 for other kinds) |

## Verification
Read misses are issued from one, two and three readers to the same block. This shows that each reader is added to the sharer set rather than replacing it: a later write miss must invalidate exactly the other readers, in ascending order. Misses to Exclusive blocks are answered with distinct owner words. Later read misses then show whether the memory was written on a read recall, and whether write-backs were accepted or ignored depending on who sent them. A second instance with a sharer limit of two receives the same reader pattern. It must invalidate a processor that never held a copy only after an overflow, which separates tracked invalidation from broadcast invalidation.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_WBACK = 2'd2,
        REQ_NOP   = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_REPLY     = 2'd0,
        MSG_INVAL     = 2'd1,
        MSG_FETCH     = 2'd2,
        MSG_FETCH_INV = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        BLK_UNCACHED = 2'd0,
        BLK_SHARED   = 2'd1,
        BLK_EXCL     = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        CTL_IDLE   = 2'd0,
        CTL_INVAL  = 2'd1,
        CTL_RECALL = 2'd2
    } ctl_state_e;

    localparam int MEM_INIT_BASE = 32'h0000_B000;

endpackage

// File: rtl/dir_mem.sv
module dir_mem #(
    parameter int NBLK   = 8,
    parameter int DATA_W = 32,
    localparam int BW    = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [BW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata
);
    import dir_pkg::*;

    logic [DATA_W-1:0] words [NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) begin
                words[i] <= DATA_W'(MEM_INIT_BASE + i);
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/dir_table.sv
module dir_table #(
    parameter int NBLK  = 8,
    parameter int NPROC = 4,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BW-1:0]         raddr,
    output dir_pkg::blk_state_e   rd_state,
    output logic [NPROC-1:0]      rd_shr,
    output logic                  rd_bc,
    input  logic                  we,
    input  logic [BW-1:0]         waddr,
    input  dir_pkg::blk_state_e   wr_state,
    input  logic [NPROC-1:0]      wr_shr,
    input  logic                  wr_bc
);
    import dir_pkg::*;

    logic [1:0]       st_arr  [NBLK];
    logic [NPROC-1:0] shr_arr [NBLK];
    logic             bc_arr  [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_ent
        logic [1:0]       st_r;
        logic [NPROC-1:0] shr_r;
        logic             bc_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r  <= BLK_UNCACHED;
                shr_r <= '0;
                bc_r  <= 1'b0;
            end else if (we && waddr == BW'(g)) begin
                st_r  <= wr_state;
                shr_r <= wr_shr;
                bc_r  <= wr_bc;
            end
        end

        assign st_arr[g]  = st_r;
        assign shr_arr[g] = shr_r;
        assign bc_arr[g]  = bc_r;
    end

    assign rd_state = blk_state_e'(st_arr[raddr]);
    assign rd_shr   = shr_arr[raddr];
    assign rd_bc    = bc_arr[raddr];

endmodule

// File: rtl/dir_lowest.sv
module dir_lowest #(
    parameter int N   = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
    parameter int NPROC     = 4,
    parameter int NBLK      = 8,
    parameter int DATA_W    = 32,
    parameter int PTR_LIMIT = 0,
    localparam int PW       = $clog2(NPROC),
    localparam int BW       = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [PW-1:0]     req_proc,
    input  logic [BW-1:0]     req_blk,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [PW-1:0]     msg_dest,
    output logic [BW-1:0]     msg_blk,
    output logic [DATA_W-1:0] msg_data
);
    import dir_pkg::*;

    typedef struct packed {
        req_kind_e     kind;
        logic [PW-1:0] proc;
        logic [BW-1:0] blk;
    } req_t;

    ctl_state_e        st_q, st_d;
    req_t              cur_q, cur_d;
    logic [PW-1:0]     own_q, own_d;
    logic [NPROC-1:0]  pend_q, pend_d;
    logic              mv_q, mv_d;
    msg_kind_e         mk_q, mk_d;
    logic [PW-1:0]     md_q, md_d;
    logic [BW-1:0]     mb_q, mb_d;
    logic [DATA_W-1:0] mdat_q, mdat_d;

    logic [BW-1:0]     tbl_raddr, tbl_waddr;
    blk_state_e        ent_st, tbl_st;
    logic [NPROC-1:0]  ent_shr, tbl_shr;
    logic              ent_bc, tbl_bc, tbl_we;

    logic [BW-1:0]     mem_raddr, mem_waddr;
    logic [DATA_W-1:0] mem_rdata, mem_wdata;
    logic              mem_we;

    logic [PW-1:0]     ent_owner, pend_idx;
    logic              pend_any, accept;
    logic [NPROC-1:0]  req_bit, cur_bit, own_bit, grow_shr, targets;
    logic              grow_bc;

    dir_table #(.NBLK(NBLK), .NPROC(NPROC)) u_table (
        .clk(clk), .rst(rst),
        .raddr(tbl_raddr), .rd_state(ent_st), .rd_shr(ent_shr), .rd_bc(ent_bc),
        .we(tbl_we), .waddr(tbl_waddr), .wr_state(tbl_st), .wr_shr(tbl_shr), .wr_bc(tbl_bc)
    );

    dir_mem #(.NBLK(NBLK), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst(rst),
        .raddr(mem_raddr), .rdata(mem_rdata),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
    );

    dir_lowest #(.N(NPROC)) u_owner_pick (.vec(ent_shr), .idx(ent_owner));
    dir_lowest #(.N(NPROC)) u_inval_pick (.vec(pend_q),  .idx(pend_idx));

    assign req_ready = (st_q == CTL_IDLE);
    assign accept    = req_valid && req_ready;
    assign pend_any  = |pend_q;
    assign req_bit   = NPROC'(1) << req_proc;
    assign cur_bit   = NPROC'(1) << cur_q.proc;
    assign own_bit   = NPROC'(1) << own_q;
    assign tbl_raddr = req_ready ? req_blk : cur_q.blk;
    assign mem_raddr = tbl_raddr;
    assign targets   = (ent_bc ? {NPROC{1'b1}} : ent_shr) & ~req_bit;

    // Adding a reader: with a pointer cap, an untracked reader beyond the cap
    // sets the broadcast flag instead of occupying a slot.
    always_comb begin
        grow_shr = ent_shr | req_bit;
        grow_bc  = ent_bc;
        if (PTR_LIMIT != 0 && (ent_shr & req_bit) == '0 &&
            $countones(ent_shr) >= PTR_LIMIT) begin
            grow_shr = ent_shr;
            grow_bc  = 1'b1;
        end
    end

    always_comb begin
        st_d      = st_q;
        cur_d     = cur_q;
        own_d     = own_q;
        pend_d    = pend_q;
        mv_d      = 1'b0;
        mk_d      = mk_q;
        md_d      = md_q;
        mb_d      = mb_q;
        mdat_d    = mdat_q;
        tbl_we    = 1'b0;
        tbl_waddr = cur_q.blk;
        tbl_st    = ent_st;
        tbl_shr   = ent_shr;
        tbl_bc    = ent_bc;
        mem_we    = 1'b0;
        mem_waddr = cur_q.blk;
        mem_wdata = rsp_data;

        unique case (st_q)
            CTL_IDLE: begin
                if (accept) begin
                    cur_d     = '{kind: req_kind_e'(req_kind), proc: req_proc, blk: req_blk};
                    tbl_waddr = req_blk;
                    mb_d      = req_blk;
                    unique case (req_kind_e'(req_kind))
                        REQ_READ: begin
                            if (ent_st == BLK_EXCL) begin
                                own_d  = ent_owner;
                                mv_d   = 1'b1;
                                mk_d   = MSG_FETCH;
                                md_d   = ent_owner;
                                mdat_d = '0;
                                st_d   = CTL_RECALL;
                            end else begin
                                tbl_we  = 1'b1;
                                tbl_st  = BLK_SHARED;
                                tbl_shr = grow_shr;
                                tbl_bc  = grow_bc;
                                mv_d    = 1'b1;
                                mk_d    = MSG_REPLY;
                                md_d    = req_proc;
                                mdat_d  = mem_rdata;
                            end
                        end
                        REQ_WRITE: begin
                            if (ent_st == BLK_EXCL) begin
                                own_d  = ent_owner;
                                mv_d   = 1'b1;
                                mk_d   = MSG_FETCH_INV;
                                md_d   = ent_owner;
                                mdat_d = '0;
                                st_d   = CTL_RECALL;
                            end else begin
                                tbl_we  = 1'b1;
                                tbl_st  = BLK_EXCL;
                                tbl_shr = req_bit;
                                tbl_bc  = 1'b0;
                                if (ent_st == BLK_SHARED && targets != '0) begin
                                    pend_d = targets;
                                    st_d   = CTL_INVAL;
                                end else begin
                                    mv_d   = 1'b1;
                                    mk_d   = MSG_REPLY;
                                    md_d   = req_proc;
                                    mdat_d = mem_rdata;
                                end
                            end
                        end
                        REQ_WBACK: begin
                            if (ent_st == BLK_EXCL && ent_shr == req_bit) begin
                                tbl_we    = 1'b1;
                                tbl_st    = BLK_UNCACHED;
                                tbl_shr   = '0;
                                tbl_bc    = 1'b0;
                                mem_we    = 1'b1;
                                mem_waddr = req_blk;
                                mem_wdata = req_data;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            CTL_INVAL: begin
                mv_d = 1'b1;
                mb_d = cur_q.blk;
                if (pend_any) begin
                    mk_d   = MSG_INVAL;
                    md_d   = pend_idx;
                    mdat_d = '0;
                    pend_d = pend_q & ~(NPROC'(1) << pend_idx);
                end else begin
                    mk_d   = MSG_REPLY;
                    md_d   = cur_q.proc;
                    mdat_d = mem_rdata;
                    st_d   = CTL_IDLE;
                end
            end
            CTL_RECALL: begin
                if (rsp_valid) begin
                    mv_d   = 1'b1;
                    mk_d   = MSG_REPLY;
                    md_d   = cur_q.proc;
                    mb_d   = cur_q.blk;
                    mdat_d = rsp_data;
                    tbl_we = 1'b1;
                    tbl_bc = 1'b0;
                    if (cur_q.kind == REQ_READ) begin
                        mem_we  = 1'b1;
                        tbl_st  = BLK_SHARED;
                        tbl_shr = own_bit | cur_bit;
                        if (PTR_LIMIT == 1 && own_q != cur_q.proc) begin
                            tbl_shr = own_bit;
                            tbl_bc  = 1'b1;
                        end
                    end else begin
                        tbl_st  = BLK_EXCL;
                        tbl_shr = cur_bit;
                    end
                    st_d = CTL_IDLE;
                end
            end
            default: st_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CTL_IDLE;
            cur_q  <= '0;
            own_q  <= '0;
            pend_q <= '0;
            mv_q   <= 1'b0;
            mk_q   <= MSG_REPLY;
            md_q   <= '0;
            mb_q   <= '0;
            mdat_q <= '0;
        end else begin
            st_q   <= st_d;
            cur_q  <= cur_d;
            own_q  <= own_d;
            pend_q <= pend_d;
            mv_q   <= mv_d;
            mk_q   <= mk_d;
            md_q   <= md_d;
            mb_q   <= mb_d;
            mdat_q <= mdat_d;
        end
    end

    assign msg_valid = mv_q;
    assign msg_kind  = mk_q;
    assign msg_dest  = md_q;
    assign msg_blk   = mb_q;
    assign msg_data  = mdat_q;

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          msg_valid,
    input logic [1:0]    msg_kind,
    input logic [PW-1:0] msg_dest
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!msg_valid && req_ready));

    // R4
    inval_order_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == 2'd1 && $past(msg_valid && msg_kind == 2'd1))
        |-> (msg_dest > $past(msg_dest)));

    // R4
    inval_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == 2'd1)
        |=> (msg_valid && (msg_kind == 2'd0 || msg_kind == 2'd1)));

    // R10
    busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind != 2'd0) |-> !req_ready);

    // R10
    reply_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == 2'd0) |-> req_ready);

    // R5
    recall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind[1]) |=> !msg_valid || msg_kind == 2'd0);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest)
);

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  kind = '0, proc = '0;
    logic [2:0]  blk = '0;
    logic [31:0] wdata = '0, fdata = '0;
    logic        va = 1'b0, vb = 1'b0, ra = 1'b0, rb = 1'b0, sel = 1'b0;

    logic        rdy_a, mv_a, rdy_b, mv_b;
    logic [1:0]  mk_a, md_a, mk_b, md_b;
    logic [2:0]  mb_a, mb_b;
    logic [31:0] mdat_a, mdat_b;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [1:0]  lk [16];
    logic [1:0]  ld [16];
    logic [31:0] ldat [16];
    int          ln = 0;

    always #4 clk = ~clk;

    dir_home_ctrl #(.NPROC(4), .NBLK(8), .DATA_W(32), .PTR_LIMIT(0)) uut (
        .clk(clk), .rst(rst), .req_valid(va), .req_ready(rdy_a), .req_kind(kind),
        .req_proc(proc), .req_blk(blk), .req_data(wdata), .rsp_valid(ra), .rsp_data(fdata),
        .msg_valid(mv_a), .msg_kind(mk_a), .msg_dest(md_a), .msg_blk(mb_a), .msg_data(mdat_a)
    );

    dir_home_ctrl #(.NPROC(4), .NBLK(8), .DATA_W(32), .PTR_LIMIT(2)) uut_lim (
        .clk(clk), .rst(rst), .req_valid(vb), .req_ready(rdy_b), .req_kind(kind),
        .req_proc(proc), .req_blk(blk), .req_data(wdata), .rsp_valid(rb), .rsp_data(fdata),
        .msg_valid(mv_b), .msg_kind(mk_b), .msg_dest(md_b), .msg_blk(mb_b), .msg_data(mdat_b)
    );

    always @(negedge clk) begin
        if ((sel ? mv_b : mv_a) && ln < 16) begin
            lk[ln]   = sel ? mk_b : mk_a;
            ld[ln]   = sel ? md_b : md_a;
            ldat[ln] = sel ? mdat_b : mdat_a;
            ln = ln + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [1:0] p, input logic [2:0] b, input logic [31:0] d);
        while (!(sel ? rdy_b : rdy_a)) @(negedge clk);
        kind = k; proc = p; blk = b; wdata = d;
        if (sel) vb = 1'b1; else va = 1'b1;
        @(negedge clk);
        va = 1'b0; vb = 1'b0;
    endtask

    task automatic respond(input logic [31:0] d);
        fdata = d;
        if (sel) rb = 1'b1; else ra = 1'b1;
        @(negedge clk);
        ra = 1'b0; rb = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // Vector fields: request kind/proc/blk/wdata, owner return data,
    // expected message count, first message kind/dest, last message kind/dest/data, requirement.
    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  proc;
        logic [2:0]  blk;
        logic [31:0] wd;
        logic [31:0] fd;
        logic [3:0]  n;
        logic [1:0]  k0;
        logic [1:0]  d0;
        logic [1:0]  kl;
        logic [1:0]  dl;
        logic [31:0] dat;
        logic [3:0]  rq;
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd0, 2'd0, 3'd1, 32'h0, 32'h0,    4'd1, 2'd0, 2'd0, 2'd0, 2'd0, 32'hB001, 4'd2},  // R2 uncached read
        '{2'd0, 2'd2, 3'd1, 32'h0, 32'h0,    4'd1, 2'd0, 2'd2, 2'd0, 2'd2, 32'hB001, 4'd2},  // R2 shared read
        '{2'd0, 2'd3, 3'd1, 32'h0, 32'h0,    4'd1, 2'd0, 2'd3, 2'd0, 2'd3, 32'hB001, 4'd2},  // R2 third reader
        '{2'd1, 2'd2, 3'd1, 32'h0, 32'h0,    4'd3, 2'd1, 2'd0, 2'd0, 2'd2, 32'hB001, 4'd4},  // R4 invals to 0,3
        '{2'd0, 2'd1, 3'd1, 32'h0, 32'h1111, 4'd2, 2'd2, 2'd2, 2'd0, 2'd1, 32'h1111, 4'd5},  // R5 fetch from 2
        '{2'd0, 2'd0, 3'd1, 32'h0, 32'h0,    4'd1, 2'd0, 2'd0, 2'd0, 2'd0, 32'h1111, 4'd5},  // R5 memory updated
        '{2'd1, 2'd0, 3'd2, 32'h0, 32'h0,    4'd1, 2'd0, 2'd0, 2'd0, 2'd0, 32'hB002, 4'd3},  // R3 uncached write
        '{2'd1, 2'd3, 3'd2, 32'h0, 32'h2222, 4'd2, 2'd3, 2'd0, 2'd0, 2'd3, 32'h2222, 4'd6},  // R6 fetch-inval to 0
        '{2'd2, 2'd3, 3'd2, 32'h3333, 32'h0, 4'd0, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0,    4'd7},  // R7 owner write-back
        '{2'd0, 2'd1, 3'd2, 32'h0, 32'h0,    4'd1, 2'd0, 2'd1, 2'd0, 2'd1, 32'h3333, 4'd7},  // R7 data landed
        '{2'd2, 2'd1, 3'd2, 32'h4444, 32'h0, 4'd0, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0,    4'd8},  // R8 write-back on shared
        '{2'd0, 2'd2, 3'd2, 32'h0, 32'h0,    4'd1, 2'd0, 2'd2, 2'd0, 2'd2, 32'h3333, 4'd8},  // R8 memory untouched
        '{2'd1, 2'd1, 3'd1, 32'h0, 32'h0,    4'd3, 2'd1, 2'd0, 2'd0, 2'd1, 32'h1111, 4'd4},  // R4 invals to 0,2
        '{2'd3, 2'd0, 3'd0, 32'h9999, 32'h0, 4'd0, 2'd0, 2'd0, 2'd0, 2'd0, 32'h0,    4'd9},  // R9 no-op code
        '{2'd0, 2'd0, 3'd0, 32'h0, 32'h0,    4'd1, 2'd0, 2'd0, 2'd0, 2'd0, 32'hB000, 4'd9}   // R9 block 0 intact
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(rdy_a == 1'b1 && mv_a == 1'b0, "R1 reset", {rdy_a, mv_a}, 32'h2);
        rst = 1'b0;
        @(negedge clk);
        chk(rdy_b == 1'b1 && mv_b == 1'b0, "R1 after reset", {rdy_b, mv_b}, 32'h2);

        // Main table walk on the full-vector instance
        for (int s = 0; s < NSTEP; s++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", STEPS[s].rq, s);
            ln = 0;
            issue(STEPS[s].kind, STEPS[s].proc, STEPS[s].blk, STEPS[s].wd);
            if (STEPS[s].n != 0 && STEPS[s].k0[1]) begin
                @(negedge clk);
                respond(STEPS[s].fd);
            end
            settle();
            chk(ln == int'(STEPS[s].n), {tag, " count"}, ln, STEPS[s].n);
            if (STEPS[s].n != 0 && ln == int'(STEPS[s].n)) begin
                chk(lk[0] == STEPS[s].k0 && ld[0] == STEPS[s].d0, {tag, " first"},
                    {lk[0], ld[0]}, {STEPS[s].k0, STEPS[s].d0});
                chk(lk[ln-1] == STEPS[s].kl && ld[ln-1] == STEPS[s].dl && ldat[ln-1] == STEPS[s].dat,
                    {tag, " last"}, ldat[ln-1], STEPS[s].dat);
                for (int i = 1; i < ln; i++) begin
                    if (lk[i] == 2'd1 && lk[i-1] == 2'd1)
                        chk(ld[i] > ld[i-1], {tag, " R4 order"}, ld[i], ld[i-1]);
                end
            end
        end

        // R10: stall while the owner's data is outstanding
        ln = 0;
        issue(2'd1, 2'd0, 3'd4, 32'h0);
        issue(2'd0, 2'd1, 3'd4, 32'h0);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(rdy_a == 1'b0, "R10 ready low in recall", rdy_a, 32'h0);
        end
        chk(ln == 2 && lk[1] == 2'd2 && ld[1] == 2'd0, "R10 only fetch sent", ln, 32'd2);
        respond(32'h5555);
        settle();
        chk(ln == 3 && lk[2] == 2'd0 && ld[2] == 2'd1 && ldat[2] == 32'h5555,
            "R5 reply after late response", ldat[2], 32'h5555);
        chk(rdy_a == 1'b1, "R10 ready after reply", rdy_a, 32'h1);

        // R11: limited instance within its cap
        sel = 1'b1;
        @(negedge clk);
        issue(2'd0, 2'd0, 3'd0, 32'h0);
        issue(2'd0, 2'd1, 3'd0, 32'h0);
        settle();
        ln = 0;
        issue(2'd1, 2'd2, 3'd0, 32'h0);
        settle();
        chk(ln == 3 && lk[0] == 2'd1 && ld[0] == 2'd0 && lk[1] == 2'd1 && ld[1] == 2'd1
            && lk[2] == 2'd0 && ld[2] == 2'd2, "R11 tracked invals only", ln, 32'd3);

        // R12: overflow makes the next write broadcast
        issue(2'd0, 2'd0, 3'd1, 32'h0);
        issue(2'd0, 2'd1, 3'd1, 32'h0);
        issue(2'd0, 2'd2, 3'd1, 32'h0);
        settle();
        ln = 0;
        issue(2'd1, 2'd1, 3'd1, 32'h0);
        settle();
        chk(ln == 4, "R12 broadcast count", ln, 32'd4);
        chk(ld[0] == 2'd0 && ld[1] == 2'd2 && ld[2] == 2'd3 && lk[2] == 2'd1,
            "R12 broadcast targets", {ld[0], ld[1], ld[2]}, {2'd0, 2'd2, 2'd3});
        chk(lk[3] == 2'd0 && ld[3] == 2'd1 && ldat[3] == 32'hB001,
            "R12 reply after broadcast", ldat[3], 32'hB001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule